// File: doc/BRIEF.md
# Paged Flash Command and Timing Controller

This block puts a small register interface in front of an emulated paged nonvolatile array. Software selects one of four registers with a 2-bit selector. It loads a byte address and a data half-word, then writes a command code. The controller then runs one of three operations: read a half-word into the data register, program a half-word, or erase the page that holds the address. Program and erase take as many clock cycles as the real array would take at the configured clock. While any operation runs, `core_stall` is held high so that the processor waits. The status register shows whether the controller is busy, whether the last command finished, whether an error occurred and whether a location was written too often.

Programming can only clear bits: the stored half-word becomes the old value ANDed with the new data. A small counter for each half-word records how many programs it has had since its page was last erased. A third or later program is still carried out, but it raises the wear and error flags, because the contents may now be corrupt. The clock rate (in kHz), the array size, the page size and the two durations are parameters, so a simulation can use short timings.

The controller has four states. IDLE waits for a command. An accepted code moves IDLE to READ, PROG or ERASE. Each of those three states returns to IDLE on the last cycle of its duration. An unknown code, or any command written while the controller is not in IDLE, leaves the state unchanged.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the status register reads 0, `core_stall` is low, the address and data registers read 0, and every array half-word holds 0xFFFF.
- R2: Selector 0 is the command register (the low byte reads back the last accepted code), 1 is the byte address, 2 is the data half-word and 3 is status. Status is read-only, and a write with selector 3 changes nothing.
- R3: Command 0x02 programs the half-word at address bits [IW:1] with stored AND data. It stays busy for exactly CLK_KHZ*PROG_US/1000 cycles.
- R4: Command 0x01 stays busy for one cycle and then loads the addressed half-word into the data register.
- R5: Command 0x03 sets all PAGE_BYTES/2 half-words of the addressed page to 0xFFFF and resets their write counts. It leaves other pages untouched and stays busy for exactly CLK_KHZ*ERASE_US/1000 cycles.
- R6: The third and every later program of one half-word since its page was erased is still carried out, and it sets status bit 3 (wear) and bit 2 (error).
- R7: Status bit 0 is busy, and bit 1 (done) is set when an operation completes. An accepted command clears done, error and wear.
- R8: A command written while busy is ignored: the running operation continues unchanged and bit 2 (error) is set. Address and data writes while busy are ignored.
- R9: `core_stall` is high exactly while status bit 0 is high.
- R10: A code other than 0x01, 0x02 or 0x03 starts no operation, sets error and leaves done clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 address, 2 data, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| core_stall | output | 1 | Holds the processor while an operation runs |

## Verification
The vector table repeatedly programs one location with overlapping bit patterns. This shows an AND merge apart from a plain overwrite, and it shows when the wear flag appears on the third program. A program to a second page followed by an erase of the first page checks that the erase reaches exactly one page and that it resets the write counts. Reads of a fresh page and of the last word of an erased page cover the 0xFFFF fill. Directed cases inject a program during an erase, address writes while busy, an unknown code and a write to status. Each of these has a distinct effect on status or on the stored data that the bench checks.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_PROG  = 2'd2,
        ST_ERASE = 2'd3
    } nvm_state_e;

    localparam logic [7:0] CMD_READ  = 8'h01;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_ERASE = 8'h03;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] count,
    output logic          last
);
    logic          run_q;
    logic [CW-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            count <= '0;
            len_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            count <= '0;
            len_q <= len;
        end else if (run_q) begin
            if (last) run_q <= 1'b0;
            else      count <= count + 1'b1;
        end
    end

    assign last = run_q && (count == len_q - 1'b1);

    AST_NO_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (len != '0));  // R3
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (count < len_q));  // R5
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int WORDS = 2048,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [15:0]   wr_data,
    output logic [1:0]    wr_uses,
    input  logic          er_en,
    input  logic [IW-1:0] er_idx
);
    logic [15:0] mem  [WORDS];
    logic [1:0]  uses [WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i]  <= 16'hFFFF;
                uses[i] <= 2'd0;
            end
        end else begin
            if (wr_en) begin
                mem[wr_idx] <= mem[wr_idx] & wr_data;
                if (uses[wr_idx] != 2'd3) uses[wr_idx] <= uses[wr_idx] + 2'd1;
            end
            if (er_en) begin
                mem[er_idx]  <= 16'hFFFF;
                uses[er_idx] <= 2'd0;
            end
        end
    end

    assign rd_data = mem[rd_idx];
    assign wr_uses = uses[wr_idx];

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem[$past(wr_idx)] & ~$past(mem[wr_idx])) == 16'h0));  // R3
    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        er_en |=> (mem[$past(er_idx)] == 16'hFFFF));  // R5
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && er_en));  // R5
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
    import nvm_pkg::*;
#(
    parameter int CLK_KHZ     = 20480,
    parameter int ARRAY_BYTES = 4096,
    parameter int PAGE_BYTES  = 512,
    parameter int PROG_US     = 50,
    parameter int ERASE_US    = 20000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        core_stall
);
    localparam int WORDS      = ARRAY_BYTES / 2;
    localparam int PAGE_WORDS = PAGE_BYTES / 2;
    localparam int IW         = $clog2(WORDS);
    localparam int POW        = $clog2(PAGE_WORDS);
    localparam int PGW        = IW - POW;
    localparam int PROG_RAW   = CLK_KHZ * PROG_US / 1000;
    localparam int ERASE_RAW  = CLK_KHZ * ERASE_US / 1000;
    localparam int PROG_CYC   = (PROG_RAW > 0) ? PROG_RAW : 1;
    localparam int ERASE_CYC  = (ERASE_RAW > PAGE_WORDS) ? ERASE_RAW : PAGE_WORDS;
    localparam int CW         = $clog2(ERASE_CYC + 1);

    nvm_state_e    state, state_n;
    logic [7:0]    cmd_q;
    logic [15:0]   addr_q, data_q;
    logic          done_q, err_q, wear_q;
    logic          busy, cmd_wr, accept, known;
    logic [CW-1:0] tmr_len, tmr_cnt;
    logic          tmr_last;
    logic [IW-1:0] idx, er_idx;
    logic          prog_wr, er_en;
    logic [15:0]   rd_data;
    logic [1:0]    wr_uses;

    assign busy   = (state != ST_IDLE);
    assign cmd_wr = reg_wr && (reg_sel == SEL_CMD);
    assign accept = cmd_wr && !busy;
    assign idx    = addr_q[IW:1];

    // next-state logic
    always_comb begin
        state_n = state;
        tmr_len = '0;
        known   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    case (reg_wdata[7:0])
                        CMD_READ:  begin state_n = ST_READ;  tmr_len = CW'(1);         known = 1'b1; end
                        CMD_PROG:  begin state_n = ST_PROG;  tmr_len = CW'(PROG_CYC);  known = 1'b1; end
                        CMD_ERASE: begin state_n = ST_ERASE; tmr_len = CW'(ERASE_CYC); known = 1'b1; end
                        default:   ;
                    endcase
                end
            end
            ST_READ, ST_PROG, ST_ERASE: if (tmr_last) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // outputs towards the array
    always_comb begin
        prog_wr = (state == ST_PROG) && tmr_last;
        er_en   = (state == ST_ERASE) && (tmr_cnt < CW'(PAGE_WORDS));
        er_idx  = {idx[IW-1 -: PGW], tmr_cnt[POW-1:0]};
    end

    nvm_cycle_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (known),
        .len   (tmr_len),
        .count (tmr_cnt),
        .last  (tmr_last)
    );

    nvm_store #(.WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx),
        .rd_data (rd_data),
        .wr_en   (prog_wr),
        .wr_idx  (idx),
        .wr_data (data_q),
        .wr_uses (wr_uses),
        .er_en   (er_en),
        .er_idx  (er_idx)
    );

    // command, status and operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            wear_q <= 1'b0;
        end else begin
            if (cmd_wr) begin
                if (busy) begin
                    err_q <= 1'b1;
                end else begin
                    cmd_q  <= reg_wdata[7:0];
                    done_q <= 1'b0;
                    wear_q <= 1'b0;
                    err_q  <= !known;
                end
            end
            if (reg_wr && !busy && reg_sel == SEL_ADDR) addr_q <= reg_wdata;
            if (reg_wr && !busy && reg_sel == SEL_DATA) data_q <= reg_wdata;
            if (state == ST_READ && tmr_last) data_q <= rd_data;
            if (tmr_last) done_q <= 1'b1;
            if (prog_wr && wr_uses >= 2'd2) begin
                err_q  <= 1'b1;
                wear_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CMD:  reg_rdata = {8'h00, cmd_q};
            SEL_ADDR: reg_rdata = addr_q;
            SEL_DATA: reg_rdata = data_q;
            SEL_STAT: reg_rdata = {12'h000, wear_q, err_q, done_q, busy};
            default:  reg_rdata = '0;
        endcase
    end

    assign core_stall = busy;

    AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stall) |-> done_q);  // R7
    AST_BUSY_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> err_q);  // R8
    AST_BUSY_REJECT_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !tmr_last) |=> (state == $past(state)));  // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));  // R8
    AST_STALL_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        known |=> core_stall);  // R9
    AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !known) |=> (!core_stall && err_q && !done_q));  // R10
endmodule

// File: tb/nvm_cmd_ctrl_bench.sv
module nvm_cmd_ctrl_bench;
    localparam int CLK_KHZ   = 100;
    localparam int PROG_CYC  = CLK_KHZ * 50 / 1000;
    localparam int ERASE_CYC = CLK_KHZ * 20000 / 1000;

    localparam logic [1:0] S_CMD = 2'd0, S_ADR = 2'd1, S_DAT = 2'd2, S_STA = 2'd3;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp_dat;
        logic [3:0]  exp_sta;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 16'h0400, 16'h0000, 16'hFFFF, 4'h2},  // R1 fresh page reads erased
        '{8'h02, 16'h0010, 16'h12F0, 16'h12F0, 4'h2},  // R3
        '{8'h01, 16'h0010, 16'h0000, 16'h12F0, 4'h2},  // R4
        '{8'h02, 16'h0010, 16'h0FFF, 16'h0FFF, 4'h2},  // R3 second write
        '{8'h01, 16'h0010, 16'h0000, 16'h02F0, 4'h2},  // R3 AND merge
        '{8'h02, 16'h0010, 16'hFFFF, 16'hFFFF, 4'hE},  // R6 third write
        '{8'h01, 16'h0010, 16'h0000, 16'h02F0, 4'h2},  // R7 flags cleared
        '{8'h02, 16'h0212, 16'hA55A, 16'hA55A, 4'h2},  // R3 other page
        '{8'h03, 16'h0000, 16'h0000, 16'h0000, 4'h2},  // R5 erase page 0
        '{8'h01, 16'h0010, 16'h0000, 16'hFFFF, 4'h2},  // R5
        '{8'h01, 16'h0212, 16'h0000, 16'hA55A, 4'h2},  // R5 neighbour kept
        '{8'h01, 16'h01FE, 16'h0000, 16'hFFFF, 4'h2},  // R5 last word of page
        '{8'h02, 16'h0010, 16'h1234, 16'h1234, 4'h2},  // R5 counts reset
        '{8'h01, 16'h0010, 16'h0000, 16'h1234, 4'h2}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        core_stall;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nvm_cmd_ctrl #(
        .CLK_KHZ(CLK_KHZ), .ARRAY_BYTES(2048), .PAGE_BYTES(512),
        .PROG_US(50), .ERASE_US(20000)
    ) u_nvm_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_stall(core_stall)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [15:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic run_cmd(input logic [7:0] code, output int n);
        wr_reg(S_CMD, {8'h00, code});
        n = 0;
        while (core_stall && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic int dur(input logic [7:0] code);
        case (code)
            8'h01:   return 1;
            8'h02:   return PROG_CYC;
            8'h03:   return ERASE_CYC;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_reg(S_STA, v); check(v == 16'h0, "R1 status", v, 0);
        check(core_stall == 1'b0, "R1 stall", core_stall, 0);
        rd_reg(S_ADR, v); check(v == 16'h0, "R1 addr", v, 0);
        rd_reg(S_DAT, v); check(v == 16'h0, "R1 data", v, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr_reg(S_ADR, VECS[i].addr);
            wr_reg(S_DAT, VECS[i].wdata);
            run_cmd(VECS[i].cmd, n);
            check(n == dur(VECS[i].cmd), "R3 R4 R5 duration", n, dur(VECS[i].cmd));
            rd_reg(S_STA, v);
            check(v[3:0] == VECS[i].exp_sta, "R6 R7 status", v, VECS[i].exp_sta);
            rd_reg(S_DAT, v);
            check(v == VECS[i].exp_dat, "R3 R4 R5 data", v, VECS[i].exp_dat);
        end

        // R2 command readback
        rd_reg(S_CMD, v); check(v == 16'h0001, "R2 cmd readback", v, 16'h0001);

        // R10 unknown code
        run_cmd(8'h7E, n);
        check(n == 0, "R10 no busy", n, 0);
        rd_reg(S_STA, v); check(v == 16'h0004, "R10 status", v, 16'h0004);
        rd_reg(S_DAT, v); check(v == 16'h1234, "R10 data kept", v, 16'h1234);

        // R2 status is read-only
        wr_reg(S_STA, 16'hFFFF);
        rd_reg(S_STA, v); check(v == 16'h0004, "R2 status write ignored", v, 16'h0004);

        // R8 R9 command and address writes during an erase
        wr_reg(S_ADR, 16'h0400);
        wr_reg(S_DAT, 16'h0000);
        wr_reg(S_CMD, 16'h0003);
        repeat (3) @(negedge clk);
        check(core_stall == 1'b1, "R9 stall while busy", core_stall, 1);
        wr_reg(S_CMD, 16'h0002);
        rd_reg(S_STA, v); check(v == 16'h0005, "R8 busy reject status", v, 16'h0005);
        wr_reg(S_ADR, 16'h0010);
        wr_reg(S_DAT, 16'hBEEF);
        n = 0;
        while (core_stall && n < 5000) begin n++; @(negedge clk); end
        check(n > ERASE_CYC - 20 && n < ERASE_CYC, "R8 erase continued", n, ERASE_CYC);
        check(core_stall == 1'b0, "R9 stall released", core_stall, 0);
        rd_reg(S_STA, v); check(v == 16'h0006, "R8 done with error", v, 16'h0006);
        rd_reg(S_ADR, v); check(v == 16'h0400, "R8 addr held", v, 16'h0400);
        rd_reg(S_DAT, v); check(v == 16'h0000, "R8 data held", v, 16'h0000);
        run_cmd(8'h01, n);
        rd_reg(S_DAT, v); check(v == 16'hFFFF, "R8 program not applied", v, 16'hFFFF);
        rd_reg(S_STA, v); check(v == 16'h0002, "R7 flags cleared", v, 16'h0002);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule